// File: doc/BRIEF.md
# Grouped Sum, Count and Average Unit

This block is a streaming aggregation operator. Each input beat carries a 32-bit unsigned value and a group number. The group number selects one of a fixed set of per-group accumulators, and that group's running total and element count are updated. One beat can be taken on every clock cycle, including runs where the same group number repeats on consecutive cycles. The unit keeps the element counts itself, so no separate vector of group sizes is supplied.

When a beat marked as the last of its stream has been taken, the unit stops accepting input and drains. It walks the groups in ascending order and skips any group that received no elements. For each remaining group it divides the total by the count with a sequential divider. It then offers one output record holding the group number, the total, the count and the truncated average. The final record is flagged as the last one. Once the drain ends, every total and count is cleared and the unit accepts the next stream. A beat whose group number lies outside the supported range adds nothing to any group and raises a saturating error counter instead.

Top module: `grp_avg_unit`

## Requirements
- R1: After reset `inReady` is 1, `outValid` is 0 and `errCount` is 0.
- R2: A record's `outSum` equals the unsigned sum, modulo 2^48, of every in-range value accepted for that group in the stream.
- R3: A record's `outCount` equals the number of beats accepted for that group in the stream.
- R4: During accumulation `inReady` stays 1, so one beat is taken every cycle. Beats with the same group number on consecutive cycles are all included in that group's totals.
- R5: A beat whose `inGroup` is 16 or more (`NUM_GROUPS`) changes no group. It raises `errCount` by one, saturating at all ones, and the counter is cleared only by reset.
- R6: After the beat with `inLast` = 1 is taken, `inReady` is 0 until the drain ends. Records leave in strictly ascending `outGroup` order, and exactly one record is sent for each group with a nonzero count.
- R7: `outAvg` equals `outSum` divided by `outCount`, truncated toward zero.
- R8: `outLast` is 1 on the final record of a drain and 0 on every other record. If no group has a nonzero count, no record is sent.
- R9: While `outValid` = 1 and `outReady` = 0, `outValid` stays 1 and every record field stays unchanged.
- R10: After the drain ends, all totals and counts are zero, and the next stream accumulates from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with `inValid` |
| inData | input | 32 | Unsigned value to accumulate |
| inGroup | input | 8 | Group number of the beat |
| inLast | input | 1 | Marks the final beat of a stream |
| outValid | output | 1 | Output record valid |
| outReady | input | 1 | Downstream takes the record when high with `outValid` |
| outLast | output | 1 | Marks the final record of a drain |
| outGroup | output | 8 | Group number of the record |
| outSum | output | 48 | Group total |
| outCount | output | 16 | Number of elements in the group |
| outAvg | output | 48 | Total divided by count, truncated |
| errCount | output | 16 | Saturating count of out-of-range beats |

## Verification
Two functions can fall in the same cycle. One is the write-back of a group's updated total from the previous beat. The other is the read of that same group for the current beat. The bench provokes this with streams built from runs of a repeated group number on consecutive cycles, without idle gaps, mixed with random streams that contain gaps and out-of-range numbers. Every record's total and count are compared with a bench model that counts each beat exactly once, so a lost or doubled update shows up as a mismatched record. Random output back-pressure is applied throughout the drain.

// File: rtl/grp_pkg.sv
package grp_pkg;

  typedef struct packed {
    logic accEn;     // accumulate the presented beat
    logic divStart;  // launch division for current group
    logic idxStep;   // move drain pointer to next group
    logic clearAll;  // wipe totals, counts and pointer
  } grp_ctrl_t;

  typedef enum logic [2:0] {
    ST_ACC,
    ST_FLUSH,
    ST_SCAN,
    ST_DIV,
    ST_OUT,
    ST_CLEAR
  } grp_state_t;

endpackage

// File: rtl/grp_divider.sv
module grp_divider #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quotient,
  output logic             done
);

  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int PROD_W = NUM_W + DEN_W;

  logic [NUM_W-1:0]  quo;
  logic [NUM_W-1:0]  numSave;
  logic [DEN_W-1:0]  rem;
  logic [DEN_W-1:0]  dsr;
  logic [STEP_W-1:0] steps;
  logic              busy;
  logic [DEN_W:0]    trial;
  logic              fits;

  always_comb begin
    trial = {rem, quo[NUM_W-1]};
    fits  = trial >= {1'b0, dsr};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo     <= '0;
      numSave <= '0;
      rem     <= '0;
      dsr     <= '0;
      steps   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      quo     <= numer;
      numSave <= numer;
      rem     <= '0;
      dsr     <= denom;
      steps   <= '0;
      busy    <= 1'b1;
      done    <= 1'b0;
    end else if (busy) begin
      if (fits) begin
        rem <= DEN_W'(trial - {1'b0, dsr});
        quo <= {quo[NUM_W-2:0], 1'b1};
      end else begin
        rem <= trial[DEN_W-1:0];
        quo <= {quo[NUM_W-2:0], 1'b0};
      end
      steps <= steps + STEP_W'(1);
      if (steps == STEP_W'(NUM_W - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient = quo;

  // Quotient must be the exact truncated result of the saved operands.
  logic [PROD_W-1:0] prod;
  always_comb prod = PROD_W'(quo) * PROD_W'(dsr);

  a_r7_quotient_exact: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (prod <= PROD_W'(numSave)) &&
             ((PROD_W'(numSave) - prod) < PROD_W'(dsr)));

endmodule

// File: rtl/grp_datapath.sv
module grp_datapath import grp_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int GID_W      = 8,
  parameter int NUM_GROUPS = 16,
  parameter int CNT_W      = 16,
  parameter int SUM_W      = 48,
  parameter int ERR_W      = 16,
  parameter int IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  grp_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] inData,
  input  logic [GID_W-1:0]  inGroup,
  output logic [IDX_W-1:0]  curIdx,
  output logic [SUM_W-1:0]  curSum,
  output logic [CNT_W-1:0]  curCount,
  output logic              curNonzero,
  output logic              idxLast,
  output logic              restEmpty,
  output logic [ERR_W-1:0]  errCount
);

  logic [SUM_W-1:0] sumMem [NUM_GROUPS];
  logic [CNT_W-1:0] cntMem [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] nzMask;

  // write-back stage registers
  logic              s1Valid;
  logic [IDX_W-1:0]  s1Gid;
  logic [DATA_W-1:0] s1Data;
  logic [SUM_W-1:0]  s1Sum;
  logic [CNT_W-1:0]  s1Cnt;

  logic              inRange;
  logic [IDX_W-1:0]  gidx;
  logic              fwdHit;
  logic [SUM_W-1:0]  wrSum;
  logic [CNT_W-1:0]  wrCnt;
  logic [SUM_W-1:0]  baseSum;
  logic [CNT_W-1:0]  baseCnt;

  always_comb begin
    inRange = 32'(inGroup) < NUM_GROUPS;
    gidx    = IDX_W'(inGroup);
    wrSum   = s1Sum + SUM_W'(s1Data);
    wrCnt   = s1Cnt + CNT_W'(1);
    fwdHit  = s1Valid && (s1Gid == gidx);
    baseSum = fwdHit ? wrSum : sumMem[gidx];
    baseCnt = fwdHit ? wrCnt : cntMem[gidx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Gid   <= '0;
      s1Data  <= '0;
      s1Sum   <= '0;
      s1Cnt   <= '0;
    end else begin
      s1Valid <= ctrl.accEn && inRange;
      if (ctrl.accEn && inRange) begin
        s1Gid  <= gidx;
        s1Data <= inData;
        s1Sum  <= baseSum;
        s1Cnt  <= baseCnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        sumMem[g] <= '0;
        cntMem[g] <= '0;
      end
    end else if (ctrl.clearAll) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        sumMem[g] <= '0;
        cntMem[g] <= '0;
      end
    end else if (s1Valid) begin
      sumMem[s1Gid] <= wrSum;
      cntMem[s1Gid] <= wrCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (ctrl.accEn && !inRange && (errCount != '1)) begin
      errCount <= errCount + ERR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx <= '0;
    end else if (ctrl.clearAll) begin
      curIdx <= '0;
    end else if (ctrl.idxStep) begin
      curIdx <= curIdx + IDX_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_nz
    assign nzMask[g] = cntMem[g] != '0;
  end

  always_comb begin
    curSum     = sumMem[curIdx];
    curCount   = cntMem[curIdx];
    curNonzero = nzMask[curIdx];
    idxLast    = 32'(curIdx) == NUM_GROUPS - 1;
    restEmpty  = ((nzMask >> curIdx) >> 1) == '0;
  end

  a_r5_err_step: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> (errCount == $past(errCount) + ERR_W'(1)));

  a_r4_forward_count: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && $past(s1Valid) && (s1Gid == $past(s1Gid)))
      |-> (s1Cnt == $past(s1Cnt) + CNT_W'(1)));

  a_r6_skip_empty: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.divStart |-> curNonzero);

  a_r10_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearAll |=> (nzMask == '0) && (curIdx == '0));

endmodule

// File: rtl/grp_control.sv
module grp_control import grp_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  output logic      inReady,
  output logic      outValid,
  input  logic      outReady,
  output logic      outLast,
  input  logic      curNonzero,
  input  logic      idxLast,
  input  logic      restEmpty,
  input  logic      divDone,
  output grp_ctrl_t ctrl
);

  grp_state_t state, stateNext;

  always_comb begin
    stateNext     = state;
    ctrl          = '0;
    inReady       = 1'b0;
    outValid      = 1'b0;
    outLast       = 1'b0;
    unique case (state)
      ST_ACC: begin
        inReady    = 1'b1;
        ctrl.accEn = inValid;
        if (inValid && inLast) stateNext = ST_FLUSH;
      end
      ST_FLUSH: stateNext = ST_SCAN;
      ST_SCAN: begin
        if (curNonzero) begin
          ctrl.divStart = 1'b1;
          stateNext     = ST_DIV;
        end else if (idxLast) begin
          stateNext = ST_CLEAR;
        end else begin
          ctrl.idxStep = 1'b1;
        end
      end
      ST_DIV: if (divDone) stateNext = ST_OUT;
      ST_OUT: begin
        outValid = 1'b1;
        outLast  = restEmpty;
        if (outReady) begin
          if (restEmpty) begin
            stateNext = ST_CLEAR;
          end else begin
            ctrl.idxStep = 1'b1;
            stateNext    = ST_SCAN;
          end
        end
      end
      ST_CLEAR: begin
        ctrl.clearAll = 1'b1;
        stateNext     = ST_ACC;
      end
      default: stateNext = ST_ACC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACC;
    else       state <= stateNext;
  end

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outLast)));

  a_r10_back_to_accept: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> !outValid ##1 inReady);

endmodule

// File: rtl/grp_avg_unit.sv
module grp_avg_unit import grp_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int GID_W      = 8,
  parameter int NUM_GROUPS = 16,
  parameter int CNT_W      = 16,
  parameter int ERR_W      = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [DATA_W-1:0]        inData,
  input  logic [GID_W-1:0]         inGroup,
  input  logic                     inLast,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     outLast,
  output logic [GID_W-1:0]         outGroup,
  output logic [DATA_W+CNT_W-1:0]  outSum,
  output logic [CNT_W-1:0]         outCount,
  output logic [DATA_W+CNT_W-1:0]  outAvg,
  output logic [ERR_W-1:0]         errCount
);

  localparam int SUM_W = DATA_W + CNT_W;
  localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  grp_ctrl_t        ctrl;
  logic [IDX_W-1:0] curIdx;
  logic [SUM_W-1:0] curSum;
  logic [CNT_W-1:0] curCount;
  logic             curNonzero;
  logic             idxLast;
  logic             restEmpty;
  logic             divDone;
  logic [SUM_W-1:0] quotient;

  grp_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inLast     (inLast),
    .inReady    (inReady),
    .outValid   (outValid),
    .outReady   (outReady),
    .outLast    (outLast),
    .curNonzero (curNonzero),
    .idxLast    (idxLast),
    .restEmpty  (restEmpty),
    .divDone    (divDone),
    .ctrl       (ctrl)
  );

  grp_datapath #(
    .DATA_W     (DATA_W),
    .GID_W      (GID_W),
    .NUM_GROUPS (NUM_GROUPS),
    .CNT_W      (CNT_W),
    .SUM_W      (SUM_W),
    .ERR_W      (ERR_W),
    .IDX_W      (IDX_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .inData     (inData),
    .inGroup    (inGroup),
    .curIdx     (curIdx),
    .curSum     (curSum),
    .curCount   (curCount),
    .curNonzero (curNonzero),
    .idxLast    (idxLast),
    .restEmpty  (restEmpty),
    .errCount   (errCount)
  );

  grp_divider #(
    .NUM_W (SUM_W),
    .DEN_W (CNT_W)
  ) i_divider (
    .clk      (clk),
    .rstN     (rstN),
    .start    (ctrl.divStart),
    .numer    (curSum),
    .denom    (curCount),
    .quotient (quotient),
    .done     (divDone)
  );

  assign outGroup = GID_W'(curIdx);
  assign outSum   = curSum;
  assign outCount = curCount;
  assign outAvg   = quotient;

endmodule

// File: tb/test_grp_avg_unit.sv
module test_grp_avg_unit;

  localparam int NG     = 16;
  localparam int GID_W  = 8;
  localparam int SUM_W  = 48;
  localparam int CNT_W  = 16;
  localparam int ERR_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [31:0]       inData = '0;
  logic [GID_W-1:0]  inGroup = '0;
  logic              inLast = 1'b0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic              outLast;
  logic [GID_W-1:0]  outGroup;
  logic [SUM_W-1:0]  outSum;
  logic [CNT_W-1:0]  outCount;
  logic [SUM_W-1:0]  outAvg;
  logic [ERR_W-1:0]  errCount;

  int checks = 0;
  int fails  = 0;

  logic [63:0] refSum [NG];
  int          refCnt [NG];
  int          refErr = 0;

  always #2 clk = ~clk;

  grp_avg_unit i_grp_avg_unit (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .inGroup(inGroup), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outLast(outLast),
    .outGroup(outGroup), .outSum(outSum), .outCount(outCount),
    .outAvg(outAvg), .errCount(errCount)
  );

  task automatic chk(input string req, input logic ok,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [63:0] expAvg(input logic [63:0] s, input int c);
    return s / 64'(c);
  endfunction

  // mode 0: random with gaps and bad ids; 1: runs of repeats; 2: group 15 only; 3: bad ids only
  task automatic runStream(input int n, input int mode);
    int  curG;
    int  runLeft;
    bit  readyOk;
    int  k;
    int  nExp;
    int  expG [NG];
    bit  held;
    logic [SUM_W-1:0] hSum, hAvg;
    logic [CNT_W-1:0] hCnt;
    logic [GID_W-1:0] hGrp;
    logic             hLast;
    int  wait_c;
    bit  extra;
    bit  lastSeen;
    for (int g = 0; g < NG; g++) begin refSum[g] = '0; refCnt[g] = 0; end
    readyOk = 1'b1;
    curG = 0; runLeft = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mode == 0) begin
        while ($urandom_range(0, 3) == 0) begin
          inValid = 1'b0;
          @(negedge clk);
        end
      end
      case (mode)
        0: curG = $urandom_range(0, 19);
        1: begin
             if (runLeft == 0) begin
               curG = $urandom_range(0, NG - 1);
               runLeft = $urandom_range(1, 6);
             end
             runLeft--;
           end
        2: curG = NG - 1;
        default: curG = $urandom_range(NG, 255);
      endcase
      inValid = 1'b1;
      inGroup = GID_W'(curG);
      inData  = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom;
      inLast  = (i == n - 1);
      if (!inReady) readyOk = 1'b0;
      if (curG < NG) begin
        refSum[curG] = (refSum[curG] + 64'(inData)) & 64'hFFFF_FFFF_FFFF;
        refCnt[curG]++;
      end else if (refErr < 65535) begin
        refErr++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    chk("R4 inReady held high while accumulating", readyOk, readyOk, 1);
    chk("R6 inReady low after last beat", !inReady, inReady, 0);

    nExp = 0;
    for (int g = 0; g < NG; g++) if (refCnt[g] != 0) begin expG[nExp] = g; nExp++; end

    k = 0; held = 1'b0; wait_c = 0; lastSeen = (nExp == 0);
    while (!lastSeen && wait_c < 20000) begin
      wait_c++;
      if (held) begin
        chk("R9 record held under back-pressure",
            outValid && outSum == hSum && outAvg == hAvg && outCount == hCnt &&
            outGroup == hGrp && outLast == hLast, longint'(outSum), longint'(hSum));
        held = 1'b0;
      end
      if (outValid) begin
        if ($urandom_range(0, 9) < 7) begin
          outReady = 1'b1;
          if (k < nExp) begin
            chk("R6 ascending group order", outGroup == GID_W'(expG[k]),
                longint'(outGroup), longint'(expG[k]));
            chk("R2 group sum", 64'(outSum) == refSum[expG[k]],
                longint'(outSum), longint'(refSum[expG[k]]));
            chk("R3 group count", int'(outCount) == refCnt[expG[k]],
                longint'(outCount), longint'(refCnt[expG[k]]));
            chk("R7 truncated average",
                64'(outAvg) == expAvg(refSum[expG[k]], refCnt[expG[k]]),
                longint'(outAvg), longint'(expAvg(refSum[expG[k]], refCnt[expG[k]])));
            chk("R8 last flag placement", outLast == (k == nExp - 1),
                longint'(outLast), longint'(k == nExp - 1));
            if (k == nExp - 1) lastSeen = 1'b1;
          end else begin
            chk("R6 no record beyond expected set", 1'b0, k + 1, nExp);
            lastSeen = 1'b1;
          end
          k++;
        end else begin
          outReady = 1'b0;
          held = 1'b1;
          hSum = outSum; hAvg = outAvg; hCnt = outCount;
          hGrp = outGroup; hLast = outLast;
        end
      end else begin
        outReady = $urandom_range(0, 1) == 1;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    chk("R6 one record per nonempty group", k == nExp, k, nExp);

    extra = 1'b0; wait_c = 0;
    while (!inReady && wait_c < 20000) begin
      if (outValid) extra = 1'b1;
      wait_c++;
      @(negedge clk);
    end
    chk("R8 no record beyond the last one", !extra, extra, 0);
    chk("R6 input reopens after drain", inReady, inReady, 1);
    chk("R5 error counter", int'(errCount) == refErr, longint'(errCount), refErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk("R1 reset inReady", inReady == 1'b1, inReady, 1);
    chk("R1 reset outValid", outValid == 1'b0, outValid, 0);
    chk("R1 reset errCount", errCount == '0, longint'(errCount), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // directed: single beat in group 15 (last index)
    runStream(1, 2);
    // directed: runs of the same group on consecutive cycles
    runStream(60, 1);
    // directed: only out-of-range ids, no records expected
    runStream(5, 3);
    // directed R10: a stream right after a drain starts from zero
    runStream(1, 2);
    // random mixes
    for (int s = 0; s < 5; s++) runStream($urandom_range(20, 150), s % 2);
    runStream(40, 2);

    summary();
    $finish;
  end

endmodule